// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Port

This block is the byte-wide register front end of a three-channel interval timer. A host drives a 2-bit address, a write enable, a read enable and a data byte. Addresses 0, 1 and 2 reach the data port of the matching channel. Address 3 is the control port. For each channel the block keeps the programmed byte-access style, the operating mode code and the BCD flag. It also keeps separate read and write byte pointers, a captured count and a captured status byte.

The counting logic is outside this block. The channels report their live 16-bit counts and their output levels on flat input vectors. In return they receive a one-cycle load strobe with a 16-bit value, plus their mode code and BCD flag. Control writes can program a channel, freeze one channel's count, or freeze the count and/or status of any group of channels with a single command. Reads hand back a frozen status first, then a frozen count, and only then the live count.

Top module: `tmr_hostport`

## Requirements
- R1: After reset, every channel uses low-then-high access, no capture is pending, every mode code and BCD flag is 0, and no load strobe is active.
- R2: A control write (address 3) whose bits [7:6] name a channel and whose bits [5:4] are non-zero stores bits [5:4] as the access style (1 low byte only, 2 high byte only, 3 low then high), bits [3:1] as the mode code and bit 0 as the BCD flag. The stored mode and BCD appear on `mode_o`/`bcd_o` from the following cycle.
- R3: In low-only style, a data write pulses that channel's `load_stb` for one cycle, one cycle after the write, with value {8'h00, byte}. In high-only style the value is {byte, 8'h00}.
- R4: In low-then-high style, the first data write produces no strobe and holds the byte. The second write strobes {second byte, first byte}.
- R5: A control write with a non-zero access field returns both byte pointers of the named channel to the low byte.
- R6: A control write with bits [5:4] = 0 captures the named channel's live count. Later reads of that channel return the captured value instead of the live count: the low byte, the high byte, or low then high, per the access style. After that, reads return the live count again.
- R7: A count capture request on a channel that still holds an unread captured count is ignored.
- R8: A control write with bits [7:6] = 3 is a group capture. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 requests a count capture and bit 4 = 0 requests a status capture. Unselected channels are untouched. The status byte is {output level, 1'b0, access style[1:0], mode[2:0], BCD}.
- R9: A pending status is read before any pending count. A status capture request is ignored while an unread status is pending.
- R10: With nothing captured, reads of the live count return the low byte (low-only style), the high byte (high-only style), or alternate low and high starting with low (low-then-high style).
- R11: A read of address 3 returns 0 and changes no pointer and no pending capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write this cycle |
| rd_en | input | 1 | Host read this cycle (ignored while wr_en is high) |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte, valid in the cycle rd_en is high |
| live_cnt | input | NCH*16 | Live count of each channel, channel i at [16i+15:16i] |
| out_lvl | input | NCH | Output level of each channel |
| load_stb | output | NCH | One-cycle load pulse per channel |
| load_val | output | NCH*16 | Load value per channel |
| mode_o | output | NCH*3 | Mode code per channel |
| bcd_o | output | NCH | BCD flag per channel |

## Verification
The hardest situation to reach is a channel that holds both a pending status and a pending count. In that state the live count and the output level have already moved on, and further capture requests arrive that must be ignored. The stimulus builds it up in order. It changes `live_cnt` and `out_lvl` after a group capture, issues a status-only and then a count-only group capture on the same channel, and only then reads. The stale status, the stale count bytes and the return to live values then show up in a fixed order. A second group capture that selects only another channel shows that unselected channels keep their live read pointers.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CNT_W  = 2 * BYTE_W;
   localparam int unsigned MODE_W = 3;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_WORD  = 2'd3
   } acc_e;

   typedef struct packed {
      acc_e              acc;
      logic [MODE_W-1:0] mode;
      logic              bcd;
   } ch_cfg_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
`timescale 1ns/1ps
module tmr_ctl_decode #(
   parameter int unsigned NCH = 3
) (
   input  logic           ctl_we,
   input  logic [7:1]     ctl_word,
   output logic [NCH-1:0] cfg_we,
   output logic [NCH-1:0] lat_cnt,
   output logic [NCH-1:0] lat_sts
);
   logic       is_grp;
   logic [1:0] acc_fld;

   assign is_grp  = (ctl_word[7:6] == 2'b11);
   assign acc_fld = ctl_word[5:4];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic named;
      logic picked;
      assign named      = (ctl_word[7:6] == 2'(i));
      assign picked     = ctl_word[i+1];
      assign cfg_we[i]  = ctl_we & ~is_grp & named & (acc_fld != 2'd0);
      assign lat_cnt[i] = ctl_we & (is_grp ? (picked & ~ctl_word[5])
                                           : (named & (acc_fld == 2'd0)));
      assign lat_sts[i] = ctl_we & is_grp & picked & ~ctl_word[4];
   end
endmodule

// File: rtl/tmr_chan_regs.sv
`timescale 1ns/1ps
module tmr_chan_regs
   import tmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_word,
   input  logic              lat_cnt,
   input  logic              lat_sts,
   input  logic              dat_we,
   input  logic              dat_re,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  live_cnt,
   input  logic              out_lvl,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              load_stb,
   output logic [CNT_W-1:0]  load_val,
   output logic [MODE_W-1:0] mode_o,
   output logic              bcd_o
);
   ch_cfg_t           cfg_q;
   logic              wr_hi_q;
   logic              rd_hi_q;
   logic [BYTE_W-1:0] wlo_q;
   logic [CNT_W-1:0]  cnt_lat_q;
   acc_e              cnt_pend_q;
   logic [BYTE_W-1:0] sts_q;
   logic              sts_pend_q;
   logic              stb_q;
   logic [CNT_W-1:0]  ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= '{acc: ACC_WORD, mode: '0, bcd: 1'b0};
         wr_hi_q    <= 1'b0;
         rd_hi_q    <= 1'b0;
         wlo_q      <= '0;
         cnt_lat_q  <= '0;
         cnt_pend_q <= ACC_LATCH;
         sts_q      <= '0;
         sts_pend_q <= 1'b0;
         stb_q      <= 1'b0;
         ld_q       <= '0;
      end else begin
         stb_q <= 1'b0;
         if (cfg_we) begin
            cfg_q   <= '{acc: acc_e'(cfg_word[5:4]), mode: cfg_word[3:1], bcd: cfg_word[0]};
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end
         if (lat_cnt && (cnt_pend_q == ACC_LATCH)) begin
            cnt_lat_q  <= live_cnt;
            cnt_pend_q <= cfg_q.acc;
         end
         if (lat_sts && !sts_pend_q) begin
            sts_q      <= {out_lvl, 1'b0, cfg_q};
            sts_pend_q <= 1'b1;
         end
         if (dat_we) begin
            case (cfg_q.acc)
               ACC_HI: begin
                  stb_q <= 1'b1;
                  ld_q  <= {wdata, {BYTE_W{1'b0}}};
               end
               ACC_WORD: begin
                  if (wr_hi_q) begin
                     stb_q   <= 1'b1;
                     ld_q    <= {wdata, wlo_q};
                     wr_hi_q <= 1'b0;
                  end else begin
                     wlo_q   <= wdata;
                     wr_hi_q <= 1'b1;
                  end
               end
               default: begin
                  stb_q <= 1'b1;
                  ld_q  <= {{BYTE_W{1'b0}}, wdata};
               end
            endcase
         end
         if (dat_re) begin
            if (sts_pend_q) begin
               sts_pend_q <= 1'b0;
            end else if (cnt_pend_q == ACC_WORD) begin
               cnt_pend_q <= ACC_HI;
            end else if (cnt_pend_q != ACC_LATCH) begin
               cnt_pend_q <= ACC_LATCH;
            end else if (cfg_q.acc == ACC_WORD) begin
               rd_hi_q <= ~rd_hi_q;
            end
         end
      end
   end

   always_comb begin
      if (sts_pend_q) begin
         rd_byte = sts_q;
      end else if (cnt_pend_q == ACC_HI) begin
         rd_byte = cnt_lat_q[CNT_W-1:BYTE_W];
      end else if (cnt_pend_q != ACC_LATCH) begin
         rd_byte = cnt_lat_q[BYTE_W-1:0];
      end else if ((cfg_q.acc == ACC_HI) || ((cfg_q.acc == ACC_WORD) && rd_hi_q)) begin
         rd_byte = live_cnt[CNT_W-1:BYTE_W];
      end else begin
         rd_byte = live_cnt[BYTE_W-1:0];
      end
   end

   assign load_stb = stb_q;
   assign load_val = ld_q;
   assign mode_o   = cfg_q.mode;
   assign bcd_o    = cfg_q.bcd;
endmodule

// File: rtl/tmr_rd_mux.sv
`timescale 1ns/1ps
module tmr_rd_mux
   import tmr_pkg::*;
#(
   parameter int unsigned NCH = 3
) (
   input  logic [1:0]            addr,
   input  logic [NCH*BYTE_W-1:0] ch_bytes,
   output logic [BYTE_W-1:0]     rdata
);
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (addr == 2'(i)) rdata = ch_bytes[i*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/tmr_hostport.sv
`timescale 1ns/1ps
module tmr_hostport
   import tmr_pkg::*;
#(
   parameter int unsigned NCH = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [1:0]            addr,
   input  logic [7:0]            wdata,
   output logic [7:0]            rdata,
   input  logic [NCH*16-1:0]     live_cnt,
   input  logic [NCH-1:0]        out_lvl,
   output logic [NCH-1:0]        load_stb,
   output logic [NCH*16-1:0]     load_val,
   output logic [NCH*3-1:0]      mode_o,
   output logic [NCH-1:0]        bcd_o
);
   localparam logic [1:0] CTL_ADDR = 2'd3;

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("tmr_hostport: NCH must be 1..3 (address 3 is the control port)");
   end
   if (CNT_W != 16 || MODE_W != 3) begin : g_bad_width
      $error("tmr_hostport: port widths assume a 16-bit count and 3-bit mode");
   end

   logic                  ctl_we;
   logic                  rd_go;
   logic [NCH-1:0]        cfg_we;
   logic [NCH-1:0]        lat_cnt;
   logic [NCH-1:0]        lat_sts;
   logic [NCH*BYTE_W-1:0] ch_bytes;

   assign ctl_we = wr_en & (addr == CTL_ADDR);
   assign rd_go  = rd_en & ~wr_en;

   tmr_ctl_decode #(.NCH(NCH)) u_dec (
      .ctl_we   (ctl_we),
      .ctl_word (wdata[7:1]),
      .cfg_we   (cfg_we),
      .lat_cnt  (lat_cnt),
      .lat_sts  (lat_sts)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      logic hit;
      assign hit = (addr == 2'(i));
      tmr_chan_regs u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we[i]),
         .cfg_word (wdata[5:0]),
         .lat_cnt  (lat_cnt[i]),
         .lat_sts  (lat_sts[i]),
         .dat_we   (wr_en & hit),
         .dat_re   (rd_go & hit),
         .wdata    (wdata),
         .live_cnt (live_cnt[i*CNT_W +: CNT_W]),
         .out_lvl  (out_lvl[i]),
         .rd_byte  (ch_bytes[i*BYTE_W +: BYTE_W]),
         .load_stb (load_stb[i]),
         .load_val (load_val[i*CNT_W +: CNT_W]),
         .mode_o   (mode_o[i*MODE_W +: MODE_W]),
         .bcd_o    (bcd_o[i])
      );
   end

   tmr_rd_mux #(.NCH(NCH)) u_mux (
      .addr     (addr),
      .ch_bytes (ch_bytes),
      .rdata    (rdata)
   );
endmodule

// File: rtl/tmr_hostport_chk.sv
`timescale 1ns/1ps
module tmr_hostport_chk #(
   parameter int unsigned NCH = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            rd_en,
   input logic [1:0]      addr,
   input logic [7:0]      rdata,
   input logic [NCH-1:0]  load_stb,
   input logic [NCH*3-1:0] mode_o,
   input logic [NCH-1:0]  bcd_o
);
   // R3: a data write loads at most one channel
   a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_stb));

   // R4: a load pulse only follows a data-port write one cycle earlier
   a_r4_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb != '0) |-> $past(wr_en && (addr != 2'd3)));

   // R2: mode and BCD change only after a control-port write
   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && (addr == 2'd3)) |-> ($stable(mode_o) && $stable(bcd_o)));

   // R11: reading the control port yields zero
   a_r11_ctl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && (addr == 2'd3)) |-> (rdata == 8'h00));
endmodule

bind tmr_hostport tmr_hostport_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tmr_hostport_tb.sv
`timescale 1ns/1ps
module tmr_hostport_tb;
   localparam int NCH = 3;
   localparam int NV  = 15;
   // vector: {op[1:0], addr[1:0], data[7:0], expect[15:0]}
   // op 0 write expecting no load, 1 write expecting load, 2 read, 3 set live count of ch0
   localparam logic [27:0] VEC [NV] = '{
      {2'd3, 2'd0, 8'h00, 16'h1234},
      {2'd2, 2'd0, 8'h00, 16'h0034},   // R1 word style from reset, low first
      {2'd2, 2'd0, 8'h00, 16'h0012},   // R10 alternation
      {2'd0, 2'd0, 8'hCD, 16'h0000},   // R4 first byte held
      {2'd1, 2'd0, 8'hAB, 16'hABCD},   // R4 pair loads
      {2'd0, 2'd3, 8'h10, 16'h0000},   // ch0 low only
      {2'd1, 2'd0, 8'h55, 16'h0055},   // R3 low only
      {2'd0, 2'd3, 8'h26, 16'h0000},   // ch0 high only, mode 3
      {2'd1, 2'd0, 8'h77, 16'h7700},   // R3 high only
      {2'd2, 2'd0, 8'h00, 16'h0012},   // R10 high only read
      {2'd2, 2'd0, 8'h00, 16'h0012},   // R10 no alternation
      {2'd0, 2'd3, 8'h34, 16'h0000},   // ch0 word, mode 2
      {2'd2, 2'd0, 8'h00, 16'h0034},   // R5 pointer back to low
      {2'd2, 2'd0, 8'h00, 16'h0012},
      {2'd2, 2'd3, 8'h00, 16'h0000}    // R11
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0;
   logic               rd_en = 1'b0;
   logic [1:0]         addr = '0;
   logic [7:0]         wdata = '0;
   logic [7:0]         rdata;
   logic [NCH*16-1:0]  live_cnt = '0;
   logic [NCH-1:0]     out_lvl = '0;
   logic [NCH-1:0]     load_stb;
   logic [NCH*16-1:0]  load_val;
   logic [NCH*3-1:0]   mode_o;
   logic [NCH-1:0]     bcd_o;

   int errors = 0;
   int checks = 0;
   logic [NCH-1:0]    cap_stb;
   logic [NCH*16-1:0] cap_val;
   logic [7:0]        rb;

   always #2.5 clk = ~clk;

   tmr_hostport #(.NCH(NCH)) u_dut (.*);

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      cap_stb = load_stb;
      cap_val = load_val;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] q);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 q = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_live(input int ch, input logic [15:0] v);
      live_cnt[ch*16 +: 16] = v;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
      logic [7:0] q;
      rd(a, q);
      check(q == e, tag, 32'(q), 32'(e));
   endtask

   task automatic wr_none(input logic [1:0] a, input logic [7:0] d, input string tag);
      wr(a, d);
      check(cap_stb == '0, tag, 32'(cap_stb), 32'h0);
   endtask

   task automatic wr_load(input int ch, input logic [7:0] d, input logic [15:0] e, input string tag);
      wr(2'(ch), d);
      check(cap_stb == NCH'(1 << ch), {tag, " strobe"}, 32'(cap_stb), 32'(1 << ch));
      check(cap_val[ch*16 +: 16] == e, {tag, " value"}, 32'(cap_val[ch*16 +: 16]), 32'(e));
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(mode_o == '0, "R1 mode after reset", 32'(mode_o), 32'h0);
      check(bcd_o == '0, "R1 bcd after reset", 32'(bcd_o), 32'h0);
      check(load_stb == '0, "R1 no strobe after reset", 32'(load_stb), 32'h0);

      // table walk on channel 0 (R1 R3 R4 R5 R10 R11)
      for (int k = 0; k < NV; k++) begin
         logic [1:0]  op;
         logic [1:0]  va;
         logic [7:0]  vd;
         logic [15:0] ve;
         {op, va, vd, ve} = VEC[k];
         case (op)
            2'd0: wr_none(va, vd, $sformatf("R4/R3 table step %0d no load", k));
            2'd1: wr_load(int'(va), vd, ve, $sformatf("R3/R4 table step %0d", k));
            2'd2: rd_chk(va, ve[7:0], $sformatf("R1/R10/R11 table step %0d read", k));
            default: set_live(0, ve);
         endcase
      end

      // R2 program channel 1: word, mode 5, BCD
      wr(2'd3, 8'h7B);
      check(mode_o[5:3] == 3'd5, "R2 ch1 mode", 32'(mode_o[5:3]), 32'd5);
      check(bcd_o[1] == 1'b1, "R2 ch1 bcd", 32'(bcd_o[1]), 32'd1);
      check(mode_o[2:0] == 3'd2, "R2 ch0 mode kept", 32'(mode_o[2:0]), 32'd2);

      // R5 write pointer reset on channel 2
      wr_none(2'd2, 8'h11, "R5 first byte");
      wr_none(2'd3, 8'hB0, "R5 reprogram");
      wr_none(2'd2, 8'h22, "R5 restarted low byte");
      wr_load(2, 8'h33, 16'h3322, "R5 pair after reset");
      set_live(2, 16'hBEEF);
      rd_chk(2'd2, 8'hEF, "R5 read low");
      wr(2'd3, 8'hB0);
      rd_chk(2'd2, 8'hEF, "R5 read pointer back to low");

      // R6 and R7 count capture on channel 0
      set_live(0, 16'h1234);
      wr(2'd3, 8'h00);
      set_live(0, 16'h5678);
      wr(2'd3, 8'h00);
      rd_chk(2'd0, 8'h34, "R7 captured low kept");
      rd_chk(2'd0, 8'h12, "R6 captured high");
      rd_chk(2'd0, 8'h78, "R6 live low after capture");
      rd_chk(2'd0, 8'h56, "R6 live high");

      // R11 control read has no effect on pointers or pending capture
      rd_chk(2'd0, 8'h78, "R11 low");
      rd_chk(2'd3, 8'h00, "R11 ctl read zero");
      rd_chk(2'd0, 8'h56, "R11 pointer unchanged");
      wr(2'd3, 8'h00);
      set_live(0, 16'h0000);
      rd_chk(2'd3, 8'h00, "R11 ctl read during capture");
      rd_chk(2'd0, 8'h78, "R11 capture still pending low");
      rd_chk(2'd0, 8'h56, "R11 capture still pending high");
      set_live(0, 16'h5678);

      // R8 and R9 group capture on channel 1
      out_lvl[1] = 1'b1;
      set_live(1, 16'hA5C3);
      wr(2'd3, 8'hC4);
      set_live(1, 16'h0000);
      out_lvl[1] = 1'b0;
      wr(2'd3, 8'hE4);
      wr(2'd3, 8'hD4);
      rd_chk(2'd1, 8'hBB, "R9 status first, R8 status layout");
      rd_chk(2'd1, 8'hC3, "R8 count low after status");
      rd_chk(2'd1, 8'hA5, "R7 count high, repeat capture ignored");
      rd_chk(2'd1, 8'h00, "R9 live low after captures");
      rd_chk(2'd1, 8'h00, "R9 live high after captures");

      // R8 group capture selecting channel 0 only
      out_lvl[0] = 1'b1;
      set_live(1, 16'h4321);
      wr(2'd3, 8'hC2);
      rd_chk(2'd1, 8'h21, "R8 unselected ch1 live low");
      rd_chk(2'd1, 8'h43, "R8 unselected ch1 live high");
      rd_chk(2'd0, 8'hB4, "R8 ch0 status");
      rd_chk(2'd0, 8'h78, "R8 ch0 count low");
      rd_chk(2'd0, 8'h56, "R8 ch0 count high");

      // R6 low-only capture on channel 2
      wr(2'd3, 8'h90);
      set_live(2, 16'hBEEF);
      wr(2'd3, 8'h80);
      set_live(2, 16'h1100);
      rd_chk(2'd2, 8'hEF, "R6 low-only captured byte");
      rd_chk(2'd2, 8'h00, "R10 low-only live byte");
      rd_chk(2'd2, 8'h00, "R10 low-only no alternation");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule